// File: doc/BRIEF.md
# Fine-Grain Round-Robin Thread Selector

This block decides, in every clock cycle, which hardware thread context may fetch into a single in-order pipeline that several threads share. Each cycle it picks a different thread from those that are able to run, rotating through the thread ids in order. Two things decide whether a thread is able to run. The first is an external per-thread ready mask. The second is an internal park state, which is set when a long-latency event (for example a cache miss) begins for that thread and is cleared when the event completes. A parked thread is skipped until its completion arrives.

The chosen thread id and a valid strobe are presented at once. They are also captured into a chain of stage slots that follows the instruction down the pipeline, one stage per cycle. A flush request carries a thread id and invalidates only the slots that belong to that thread, including the choice being captured in the same cycle. Slots owned by other threads keep moving untouched. With four threads on a five-stage pipeline and every thread running, a thread is granted once every four cycles, so its previous instruction has reached write-back before the next one reads registers.

Top module: `mt_thread_sel`

## Requirements
- R1: After reset no thread is parked, every stage slot is invalid, and the rotation pointer is at thread 0, so with all threads ready the first grant goes to thread 0.
- R2: A thread is eligible when its bit in `thr_ready` is 1 and it is not parked. The grant is the first eligible thread found by searching upward from the pointer and wrapping. After a grant the pointer moves to the granted id plus one, modulo the thread count.
- R3: When no thread is eligible, `sel_valid` is 0 and the pointer keeps its value.
- R4: An `evt_start` pulse parks the thread `evt_start_tid`, starting with the next cycle's selection.
- R5: An `evt_done` pulse unparks the thread `evt_done_tid`, starting with the next cycle's selection.
- R6: If `evt_start` and `evt_done` name the same thread in one cycle, the thread is parked afterwards.
- R7: Stage slot 0 captures `sel_valid` and `sel_tid` at each clock edge, and slot i captures slot i-1. The id of slot i sits at bits [i*TID_W +: TID_W] of `stage_tid`, and its valid bit is bit i of `stage_valid`.
- R8: When `flush_req` is high, every value that moves into a slot at that edge (the current selection going into slot 0, and slot i-1 going into slot i) arrives invalid if its id equals `flush_tid`. Values with other ids arrive unchanged.
- R9: While all threads stay eligible, each thread is granted exactly once in every window of N_THREADS consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_ready | input | N_THREADS | Per-thread external ready mask |
| evt_start | input | 1 | Long-latency event begins |
| evt_start_tid | input | TID_W | Thread that begins the event |
| evt_done | input | 1 | Long-latency event completes |
| evt_done_tid | input | TID_W | Thread whose event completes |
| flush_req | input | 1 | Kill in-flight slots of one thread |
| flush_tid | input | TID_W | Thread to be flushed |
| sel_valid | output | 1 | A thread is granted this cycle |
| sel_tid | output | TID_W | Granted thread id |
| stage_valid | output | N_STAGES | Valid bit of each stage slot |
| stage_tid | output | N_STAGES*TID_W | Thread id of each stage slot, packed |

## Verification
The assertions assume that every thread id on `evt_start_tid`, `evt_done_tid` and `flush_tid` is below N_THREADS. They also assume that a completion for a thread that is not parked is harmless, which the design's behaviour guarantees. The bench only draws ids from 0 to N_THREADS-1. It lets starts, completions and flushes arrive in any combination, including a start and a completion for the same thread in one cycle and completions for threads that are not parked, because the block defines a result for each of these cases.

// File: rtl/mt_sel_pkg.sv
// Package: shared defaults and helpers for the thread selector.
// Assumes: nothing; pure constants and a width function.
package mt_sel_pkg;

    localparam int DEF_THREADS = 4;
    localparam int DEF_STAGES  = 5;

    // Bits needed to hold a thread id; at least one.
    function automatic int tid_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mt_park_track.sv
// Module: per-thread park state for long-latency events.
// A start pulse sets the thread's park bit and a completion clears it.
// When both name the same thread in one cycle, the start wins.
// Assumes: ids are below N_THREADS; synchronous active-low reset.
module mt_park_track #(
    parameter int N_THREADS = 4,
    parameter int TID_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_start,
    input  logic [TID_W-1:0]     evt_start_tid,
    input  logic                 evt_done,
    input  logic [TID_W-1:0]     evt_done_tid,
    output logic [N_THREADS-1:0] parked
);

    for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
        logic hit_start;
        logic hit_done;

        // Decode whether this thread is named by either pulse.
        always_comb begin
            hit_start = evt_start && (evt_start_tid == TID_W'(t));
            hit_done  = evt_done  && (evt_done_tid  == TID_W'(t));
        end

        // Park bit update; a start takes priority over a completion.
        always_ff @(posedge clk) begin
            if (!rst_n)         parked[t] <= 1'b0;
            else if (hit_start) parked[t] <= 1'b1;
            else if (hit_done)  parked[t] <= 1'b0;
        end
    end

endmodule

// File: rtl/mt_rr_sel.sv
// Module: rotating selector over an eligibility mask.
// It grants the first eligible thread at or above the pointer, wrapping
// around, and then moves the pointer just past the granted id.
// Assumes: synchronous active-low reset; the pointer starts at 0.
module mt_rr_sel #(
    parameter int N_THREADS = 4,
    parameter int TID_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_THREADS-1:0] elig,
    output logic                 gnt_valid,
    output logic [TID_W-1:0]     gnt_tid
);

    logic [TID_W-1:0] ptr_q;
    logic [TID_W-1:0] ptr_d;

    // Search from the pointer; a smaller offset overrides a larger one.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_tid   = '0;
        for (int k = N_THREADS - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(ptr_q) + k) % N_THREADS;
            if (elig[idx]) begin
                gnt_valid = 1'b1;
                gnt_tid   = TID_W'(idx);
            end
        end
    end

    // Next pointer: one past the grant, wrapping; hold when nothing is granted.
    always_comb begin
        ptr_d = ptr_q;
        if (gnt_valid)
            ptr_d = TID_W'((int'(gnt_tid) + 1) % N_THREADS);
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

endmodule

// File: rtl/mt_slot_pipe.sv
// Module: chain of stage slots that carry a valid bit and a thread id.
// Each value moving into a slot is killed when a flush names its id.
// Assumes: synchronous active-low reset; slot i's id is packed at i*TID_W.
module mt_slot_pipe #(
    parameter int N_STAGES = 5,
    parameter int TID_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [TID_W-1:0]          in_tid,
    input  logic                      flush_req,
    input  logic [TID_W-1:0]          flush_tid,
    output logic [N_STAGES-1:0]       slot_valid,
    output logic [N_STAGES*TID_W-1:0] slot_tid
);

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        logic             src_v;
        logic [TID_W-1:0] src_t;
        logic             kill;

        // Source of this slot: the selection for slot 0, the previous slot otherwise.
        if (i == 0) begin : g_head
            always_comb begin
                src_v = in_valid;
                src_t = in_tid;
            end
        end else begin : g_body
            always_comb begin
                src_v = slot_valid[i-1];
                src_t = slot_tid[(i-1)*TID_W +: TID_W];
            end
        end

        // Thread-aware kill of the value moving in.
        always_comb kill = flush_req && (src_t == flush_tid);

        // Slot register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_valid[i]                <= 1'b0;
                slot_tid[i*TID_W +: TID_W]   <= '0;
            end else begin
                slot_valid[i]                <= src_v && !kill;
                slot_tid[i*TID_W +: TID_W]   <= src_t;
            end
        end
    end

endmodule

// File: rtl/mt_thread_sel.sv
// Module: fine-grain round-robin thread selector with thread-tagged slots.
// Eligibility is the ready mask with parked threads removed. A rotating
// selector grants one thread per cycle, and the grant is carried down a
// chain of stage slots that honours flushes aimed at a single thread.
// Assumes: ids on event and flush inputs are below N_THREADS.
module mt_thread_sel
    import mt_sel_pkg::*;
#(
    parameter int N_THREADS = DEF_THREADS,
    parameter int N_STAGES  = DEF_STAGES,
    parameter int TID_W     = tid_bits(N_THREADS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_THREADS-1:0]      thr_ready,
    input  logic                      evt_start,
    input  logic [TID_W-1:0]          evt_start_tid,
    input  logic                      evt_done,
    input  logic [TID_W-1:0]          evt_done_tid,
    input  logic                      flush_req,
    input  logic [TID_W-1:0]          flush_tid,
    output logic                      sel_valid,
    output logic [TID_W-1:0]          sel_tid,
    output logic [N_STAGES-1:0]       stage_valid,
    output logic [N_STAGES*TID_W-1:0] stage_tid
);

    logic [N_THREADS-1:0] parked_q;
    logic [N_THREADS-1:0] elig;

    // Threads that may be granted this cycle.
    always_comb elig = thr_ready & ~parked_q;

    mt_park_track #(
        .N_THREADS (N_THREADS),
        .TID_W     (TID_W)
    ) u_park (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_start     (evt_start),
        .evt_start_tid (evt_start_tid),
        .evt_done      (evt_done),
        .evt_done_tid  (evt_done_tid),
        .parked        (parked_q)
    );

    mt_rr_sel #(
        .N_THREADS (N_THREADS),
        .TID_W     (TID_W)
    ) u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .gnt_valid (sel_valid),
        .gnt_tid   (sel_tid)
    );

    mt_slot_pipe #(
        .N_STAGES (N_STAGES),
        .TID_W    (TID_W)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (sel_valid),
        .in_tid     (sel_tid),
        .flush_req  (flush_req),
        .flush_tid  (flush_tid),
        .slot_valid (stage_valid),
        .slot_tid   (stage_tid)
    );

endmodule

// File: rtl/mt_thread_sel_chk.sv
// Module: assertion checker bound to mt_thread_sel.
// Assumes: ids on event and flush inputs are below N_THREADS.
module mt_thread_sel_chk #(
    parameter int N_THREADS = 4,
    parameter int N_STAGES  = 5,
    parameter int TID_W     = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_THREADS-1:0]      thr_ready,
    input logic [N_THREADS-1:0]      parked_q,
    input logic                      evt_start,
    input logic [TID_W-1:0]          evt_start_tid,
    input logic                      evt_done,
    input logic [TID_W-1:0]          evt_done_tid,
    input logic                      flush_req,
    input logic [TID_W-1:0]          flush_tid,
    input logic                      sel_valid,
    input logic [TID_W-1:0]          sel_tid,
    input logic [N_STAGES-1:0]       stage_valid,
    input logic [N_STAGES*TID_W-1:0] stage_tid
);

    // A grant only goes to a ready, unparked thread.
    assert_grant_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (thr_ready[sel_tid] && !parked_q[sel_tid]));

    // Nothing eligible means no grant.
    assert_idle_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_ready & ~parked_q) == '0) |-> !sel_valid);

    // An event start parks its thread from the next cycle.
    assert_start_parks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_start |=> parked_q[$past(evt_start_tid)]);

    // A completion unparks its thread unless the same thread starts again (R6).
    assert_done_unparks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && !(evt_start && evt_start_tid == evt_done_tid))
            |=> !parked_q[$past(evt_done_tid)]);

    // An unflushed grant lands in slot 0.
    assert_slot0_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !(flush_req && flush_tid == sel_tid))
            |=> (stage_valid[0] && stage_tid[TID_W-1:0] == $past(sel_tid)));

    // A flushed grant never lands in slot 0.
    assert_slot0_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_tid == sel_tid) |=> !stage_valid[0]);

    for (genvar i = 0; i + 1 < N_STAGES; i++) begin : g_adv
        // A matching slot is killed as it advances.
        assert_slot_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_req && stage_valid[i] && stage_tid[i*TID_W +: TID_W] == flush_tid)
                |=> !stage_valid[i+1]);

        // A non-matching slot advances intact.
        assert_slot_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (stage_valid[i] && !(flush_req && stage_tid[i*TID_W +: TID_W] == flush_tid))
                |=> (stage_valid[i+1] &&
                     stage_tid[(i+1)*TID_W +: TID_W] == $past(stage_tid[i*TID_W +: TID_W])));
    end

endmodule

bind mt_thread_sel mt_thread_sel_chk #(
    .N_THREADS (N_THREADS),
    .N_STAGES  (N_STAGES),
    .TID_W     (TID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .thr_ready     (thr_ready),
    .parked_q      (parked_q),
    .evt_start     (evt_start),
    .evt_start_tid (evt_start_tid),
    .evt_done      (evt_done),
    .evt_done_tid  (evt_done_tid),
    .flush_req     (flush_req),
    .flush_tid     (flush_tid),
    .sel_valid     (sel_valid),
    .sel_tid       (sel_tid),
    .stage_valid   (stage_valid),
    .stage_tid     (stage_tid)
);

// File: tb/mt_thread_sel_test.sv
// Bench: behavioural per-cycle model of the selector, compared every clock.
module mt_thread_sel_test;

    localparam int NT = 4;
    localparam int NS = 5;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] thr_ready = '1;
    logic          evt_start = 1'b0;
    logic [TW-1:0] evt_start_tid = '0;
    logic          evt_done = 1'b0;
    logic [TW-1:0] evt_done_tid = '0;
    logic          flush_req = 1'b0;
    logic [TW-1:0] flush_tid = '0;
    logic          sel_valid;
    logic [TW-1:0] sel_tid;
    logic [NS-1:0] stage_valid;
    logic [NS*TW-1:0] stage_tid;

    int total = 0;
    int bad = 0;

    // Reference state.
    int m_ptr;
    bit m_park [NT];
    bit m_sv [NS];
    int m_st [NS];
    int grant_hist [$];

    always #4 clk = ~clk;

    mt_thread_sel #(.N_THREADS(NT), .N_STAGES(NS)) uut (
        .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready),
        .evt_start(evt_start), .evt_start_tid(evt_start_tid),
        .evt_done(evt_done), .evt_done_tid(evt_done_tid),
        .flush_req(flush_req), .flush_tid(flush_tid),
        .sel_valid(sel_valid), .sel_tid(sel_tid),
        .stage_valid(stage_valid), .stage_tid(stage_tid)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_ptr = 0;
        for (int t = 0; t < NT; t++) m_park[t] = 0;
        for (int i = 0; i < NS; i++) begin m_sv[i] = 0; m_st[i] = 0; end
        grant_hist.delete();
    endfunction

    // One cycle: compare outputs mid-low-phase, then advance the model.
    task automatic step(input string tag);
        bit ev;
        int et;
        int sv_pack;
        int sv_exp;
        #2;
        ev = 0; et = 0;
        for (int k = 0; k < NT; k++) begin
            int idx;
            idx = (m_ptr + k) % NT;
            if (!ev && thr_ready[idx] && !m_park[idx]) begin ev = 1; et = idx; end
        end
        check({tag, " sel_valid"}, int'(sel_valid), int'(ev));
        if (ev) check({tag, " sel_tid"}, int'(sel_tid), et);
        sv_exp = 0;
        for (int i = 0; i < NS; i++) if (m_sv[i]) sv_exp |= (1 << i);
        sv_pack = int'(stage_valid);
        check({tag, " stage_valid"}, sv_pack, sv_exp);
        for (int i = 0; i < NS; i++)
            if (m_sv[i]) check({tag, " stage_tid"}, int'(stage_tid[i*TW +: TW]), m_st[i]);
        // advance slots (flush qualified)
        for (int i = NS - 1; i >= 1; i--) begin
            m_sv[i] = m_sv[i-1] && !(flush_req && m_st[i-1] == int'(flush_tid));
            m_st[i] = m_st[i-1];
        end
        m_sv[0] = ev && !(flush_req && et == int'(flush_tid));
        m_st[0] = et;
        // park: done first, start overrides
        if (evt_done)  m_park[evt_done_tid]  = 0;
        if (evt_start) m_park[evt_start_tid] = 1;
        if (ev) m_ptr = (et + 1) % NT;
        grant_hist.push_back(ev ? et : -1);
        @(negedge clk);
        evt_start = 0; evt_done = 0; flush_req = 0;
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        check("R1 reset stage_valid", int'(stage_valid), 0);
        check("R1 reset first grant", int'(sel_tid), 0);
        check("R1 reset sel_valid", int'(sel_valid), 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();

        // R2 / R9: all threads ready
        for (int c = 0; c < 12; c++) step("R2");
        for (int c = 0; c + NT <= grant_hist.size(); c++) begin
            int seen;
            seen = 0;
            for (int k = 0; k < NT; k++)
                if (grant_hist[c+k] >= 0) seen |= (1 << grant_hist[c+k]);
            check("R9 window", seen, (1 << NT) - 1);
        end

        // R2 / R3: ready mask patterns
        thr_ready = 4'b1010; for (int c = 0; c < 5; c++) step("R2 mask");
        thr_ready = 4'b0001; for (int c = 0; c < 3; c++) step("R2 single");
        thr_ready = 4'b0000; for (int c = 0; c < 3; c++) step("R3 none");
        thr_ready = 4'b0110; for (int c = 0; c < 3; c++) step("R3 resume");
        thr_ready = '1;

        // R4: park thread 2
        evt_start = 1; evt_start_tid = 2; step("R4 start");
        for (int c = 0; c < 6; c++) step("R4 parked");
        // R5: unpark thread 2
        evt_done = 1; evt_done_tid = 2; step("R5 done");
        for (int c = 0; c < 5; c++) step("R5 back");
        // R6: start and done together on thread 1
        evt_start = 1; evt_start_tid = 1; step("R6 park");
        evt_start = 1; evt_start_tid = 1; evt_done = 1; evt_done_tid = 1; step("R6 both");
        for (int c = 0; c < 5; c++) step("R6 stays");
        evt_done = 1; evt_done_tid = 1; step("R6 release");
        for (int c = 0; c < 4; c++) step("R7 flow");

        // R8: flush thread 1 with all running
        flush_req = 1; flush_tid = 1; step("R8 flush");
        for (int c = 0; c < 3; c++) step("R8 after");
        // R8: only thread 0 runs, fills every slot, then flush it
        thr_ready = 4'b0001;
        for (int c = 0; c < 6; c++) step("R7 single");
        flush_req = 1; flush_tid = 0; step("R8 all slots");
        for (int c = 0; c < 3; c++) step("R8 refill");
        thr_ready = 4'b0011;
        flush_req = 1; flush_tid = 3; step("R8 no match");
        for (int c = 0; c < 3; c++) step("R8 intact");

        // Mixed traffic
        for (int c = 0; c < 400; c++) begin
            thr_ready = NT'($urandom);
            if ($urandom % 4 == 0) begin evt_start = 1; evt_start_tid = TW'($urandom); end
            if ($urandom % 3 == 0) begin evt_done = 1; evt_done_tid = TW'($urandom); end
            if ($urandom % 5 == 0) begin flush_req = 1; flush_tid = TW'($urandom); end
            step("R2 R8 mixed");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule